// File: doc/BRIEF.md
# Address Breakpoint Match Unit

This unit checks each memory access against four programmable breakpoint entries. Each entry holds a 64-bit base, a 64-bit compare mask and three enables: read, write and execute. A data access is matched byte by byte over its whole footprint of 1 to 16 bytes. An instruction fetch is matched on its first byte only. A match is presented one cycle later as a per-entry hit vector. For a fetch the unit also raises `fault`. For a data access it also raises `trap`.

The access descriptor carries an operation class. Some classes are exempt from data reporting. One class is widened to a 16-byte footprint. Hits from register-stack-engine accesses are not reported at once. They are parked in a deferral state machine with two states:

- `DF_EMPTY` is the state with nothing parked.
- `DF_HELD` is the state with hits parked.

The machine has four transitions:

- **STASH** (`DF_EMPTY` to `DF_HELD`): a stack-engine hit arrives.
- **MERGE** (`DF_HELD` to `DF_HELD`, no commit): further stack-engine hits are OR-ed into the parked set.
- **RELOAD** (`DF_HELD` to `DF_HELD` on commit): the parked set is released and a hit arriving in the same cycle becomes the new parked set.
- **DRAIN** (`DF_HELD` to `DF_EMPTY` on commit): the parked set is released and no new hit arrives.

A released set is reported as a data trap.

Top module: `bkpt_match_unit`

## Requirements
- R1: A byte address B matches an entry when (B AND mask) equals (base AND mask); a mask bit of 1 means the bit is compared. A data access covers bytes start through start+len_m1 (the length field holds size minus one, so 0..15 means 1..16 bytes). The access hits when any covered byte matches, including operands that cross a region edge, and the byte sequence wraps from the top of the 64-bit space to zero.
- R2: A data access reports no hit for an entry when none of its covered bytes lies in that entry's masked region, whatever its alignment.
- R3: A data read needs the entry's read enable and a data write needs its write enable. An entry with both of these enables clear never matches data.
- R4: An instruction fetch (`acc_instr`=1) compares only its start address against entries with the execute enable set.
- R5: In 32-bit mode (`acc_mode32`=1), a fetch can only match an entry whose base bits 63:32 are all zero.
- R6: A data access of class 1 (wide compare-exchange) is matched as 16 bytes from its start address, for both reads and writes, whatever its length field.
- R7: Data accesses of classes 2 to 7 report nothing. These classes are cache flush, regular probe, non-faulting prefetch, TLB insert, TLB purge and translation access. Classes 0 and 9 to 15 are ordinary.
- R8: A data access of class 8 (stack engine) that matches reports nothing at the time. Its hits are parked. On a later `commit` pulse they appear in `hit_vec` with `trap`=1. A `commit` with nothing parked reports nothing.
- R9: Parked hits are never lost. Further stack-engine hits merge into the parked set. A commit in the same cycle as a new stack-engine hit releases the old set and parks the new one. A commit in the same cycle as an ordinary data hit reports the union of the two.
- R10: Outputs are registered. They reflect the access (and commit) from the previous cycle only, for one cycle. With no valid access and no commit they return to zero.
- R11: Reset clears every entry's enables, the outputs and the parked hits.
- R12: `fault` marks a fetch hit and `trap` marks a data hit. A nonzero `hit_vec` always comes with one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_load | input | 1 | Write one breakpoint entry this cycle |
| bp_sel | input | 2 | Entry index to write |
| bp_base | input | 64 | Entry base address |
| bp_mask | input | 64 | Entry compare mask (1 = compare) |
| bp_rd_en | input | 1 | Entry read enable |
| bp_wr_en | input | 1 | Entry write enable |
| bp_ex_en | input | 1 | Entry execute enable |
| acc_valid | input | 1 | Access descriptor valid |
| acc_addr | input | 64 | Start byte address |
| acc_len_m1 | input | 4 | Access size minus one |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_instr | input | 1 | 1 = instruction fetch |
| acc_mode32 | input | 1 | 32-bit mode access |
| acc_class | input | 4 | Operation class code |
| commit | input | 1 | Stack-engine commit strobe |
| hit_vec | output | 4 | Registered per-entry hit vector |
| fault | output | 1 | Registered fetch breakpoint |
| trap | output | 1 | Registered data breakpoint |

## Verification
Two functions can fall into the same cycle: the release of parked stack-engine hits on `commit`, and a fresh match from the access presented in that cycle. The bench drives `commit` together with a new stack-engine hit, together with an ordinary data hit, and together with a fetch hit. It judges the output vector as the union of the released and fresh ordinary hits. It then confirms on a following commit that a freshly parked hit was neither reported early nor dropped.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;

    localparam int BKPT_AW = 64;

    typedef enum logic [3:0] {
        OPC_PLAIN     = 4'd0,
        OPC_WIDE_CX   = 4'd1,
        OPC_FLUSH     = 4'd2,
        OPC_PROBE     = 4'd3,
        OPC_PFETCH_NF = 4'd4,
        OPC_TLB_INS   = 4'd5,
        OPC_TLB_PURGE = 4'd6,
        OPC_XLATE     = 4'd7,
        OPC_STACK_ENG = 4'd8
    } opclass_e;

    typedef struct packed {
        logic [BKPT_AW-1:0] base;
        logic [BKPT_AW-1:0] mask;
        logic               rd_en;
        logic               wr_en;
        logic               ex_en;
    } bp_entry_t;

    function automatic logic class_exempt(input logic [3:0] c);
        return (c >= 4'(OPC_FLUSH)) && (c <= 4'(OPC_XLATE));
    endfunction

endpackage

// File: rtl/bkpt_regs.sv
`timescale 1ns/1ps
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int NUM_BP = 4,
    localparam int SEL_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld,
    input  logic [SEL_W-1:0]       ld_sel,
    input  bp_entry_t              ld_entry,
    output bp_entry_t [NUM_BP-1:0] entries
);

    for (genvar g = 0; g < NUM_BP; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[g] <= '0;
            end else if (ld && (ld_sel == SEL_W'(g))) begin
                entries[g] <= ld_entry;
            end
        end
    end

endmodule

// File: rtl/bkpt_cmp.sv
`timescale 1ns/1ps
module bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int LEN_W = $clog2(MAX_LEN)
) (
    input  bp_entry_t          entry,
    input  logic [BKPT_AW-1:0] start,
    input  logic [LEN_W-1:0]   len_m1,
    input  logic               is_instr,
    input  logic               mode32,
    input  logic               is_write,
    output logic               match
);

    logic [MAX_LEN-1:0] byte_hit;
    logic               fetch_ok;
    logic               perm_ok;

    // one masked compare per byte lane; address arithmetic wraps mod 2^64
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_lane
        logic [BKPT_AW-1:0] lane_addr;
        assign lane_addr   = start + BKPT_AW'(i);
        assign byte_hit[i] = ({1'b0, len_m1} >= (LEN_W+1)'(i)) &&
                             (((lane_addr ^ entry.base) & entry.mask) == '0);
    end

    always_comb begin
        fetch_ok = entry.ex_en &&
                   (((start ^ entry.base) & entry.mask) == '0) &&
                   (!mode32 || (entry.base[BKPT_AW-1:32] == '0));
        perm_ok  = is_write ? entry.wr_en : entry.rd_en;
        match    = is_instr ? fetch_ok : (perm_ok && (|byte_hit));
    end

endmodule

// File: rtl/bkpt_defer.sv
`timescale 1ns/1ps
module bkpt_defer #(
    parameter int NUM_BP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BP-1:0] stash_vec,
    input  logic              commit,
    output logic [NUM_BP-1:0] release_vec
);

    typedef enum logic {DF_EMPTY, DF_HELD} df_state_e;

    df_state_e         state_q, state_d;
    logic [NUM_BP-1:0] pend_q, pend_d;

    // next state: STASH, MERGE, RELOAD, DRAIN
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            DF_EMPTY: begin
                pend_d  = stash_vec;
                state_d = (|stash_vec) ? DF_HELD : DF_EMPTY;
            end
            DF_HELD: begin
                if (commit) begin
                    pend_d  = stash_vec;
                    state_d = (|stash_vec) ? DF_HELD : DF_EMPTY;
                end else begin
                    pend_d  = pend_q | stash_vec;
                    state_d = DF_HELD;
                end
            end
            default: begin
                pend_d  = '0;
                state_d = DF_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DF_EMPTY;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // outputs
    always_comb begin
        release_vec = '0;
        unique case (state_q)
            DF_EMPTY: release_vec = '0;
            DF_HELD:  release_vec = commit ? pend_q : '0;
            default:  release_vec = '0;
        endcase
    end

endmodule

// File: rtl/bkpt_match_unit.sv
`timescale 1ns/1ps
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int NUM_BP  = 4,
    parameter int MAX_LEN = 16,
    localparam int SEL_W  = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
    localparam int LEN_W  = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bp_load,
    input  logic [SEL_W-1:0]   bp_sel,
    input  logic [BKPT_AW-1:0] bp_base,
    input  logic [BKPT_AW-1:0] bp_mask,
    input  logic               bp_rd_en,
    input  logic               bp_wr_en,
    input  logic               bp_ex_en,
    input  logic               acc_valid,
    input  logic [BKPT_AW-1:0] acc_addr,
    input  logic [LEN_W-1:0]   acc_len_m1,
    input  logic               acc_write,
    input  logic               acc_instr,
    input  logic               acc_mode32,
    input  logic [3:0]         acc_class,
    input  logic               commit,
    output logic [NUM_BP-1:0]  hit_vec,
    output logic               fault,
    output logic               trap
);

    bp_entry_t [NUM_BP-1:0] entries;
    bp_entry_t              new_entry;
    logic [LEN_W-1:0]       eff_len;
    logic [NUM_BP-1:0]      raw_vec, now_vec, stash_vec, release_vec;
    logic                   is_data, exempt, stack_acc;

    assign new_entry = '{base: bp_base, mask: bp_mask, rd_en: bp_rd_en,
                         wr_en: bp_wr_en, ex_en: bp_ex_en};

    bkpt_regs #(.NUM_BP(NUM_BP)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (bp_load),
        .ld_sel   (bp_sel),
        .ld_entry (new_entry),
        .entries  (entries)
    );

    always_comb begin
        is_data   = acc_valid && !acc_instr;
        exempt    = is_data && class_exempt(acc_class);
        stack_acc = is_data && (acc_class == 4'(OPC_STACK_ENG));
        eff_len   = (is_data && (acc_class == 4'(OPC_WIDE_CX)))
                    ? LEN_W'(MAX_LEN - 1) : acc_len_m1;
    end

    for (genvar b = 0; b < NUM_BP; b++) begin : g_cmp
        bkpt_cmp #(.MAX_LEN(MAX_LEN)) u_cmp (
            .entry    (entries[b]),
            .start    (acc_addr),
            .len_m1   (eff_len),
            .is_instr (acc_instr),
            .mode32   (acc_mode32),
            .is_write (acc_write),
            .match    (raw_vec[b])
        );
    end

    always_comb begin
        now_vec   = (acc_valid && !exempt && !stack_acc) ? raw_vec : '0;
        stash_vec = stack_acc ? raw_vec : '0;
    end

    bkpt_defer #(.NUM_BP(NUM_BP)) u_defer (
        .clk         (clk),
        .rst_n       (rst_n),
        .stash_vec   (stash_vec),
        .commit      (commit),
        .release_vec (release_vec)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_vec <= '0;
            fault   <= 1'b0;
            trap    <= 1'b0;
        end else begin
            hit_vec <= now_vec | release_vec;
            fault   <= acc_valid && acc_instr && (|now_vec);
            trap    <= (is_data && (|now_vec)) || (|release_vec);
        end
    end

endmodule

// File: rtl/bkpt_chk.sv
`timescale 1ns/1ps
module bkpt_chk #(
    parameter int NUM_BP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_instr,
    input logic [3:0]        acc_class,
    input logic              commit,
    input logic [NUM_BP-1:0] hit_vec,
    input logic              fault,
    input logic              trap
);

    // R7
    exempt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_instr && acc_class >= 4'd2 && acc_class <= 4'd7 && !commit)
        |=> (hit_vec == '0 && !trap && !fault));

    // R8
    stack_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_instr && acc_class == 4'd8 && !commit)
        |=> (hit_vec == '0 && !trap));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !commit) |=> (hit_vec == '0 && !fault && !trap));

    // R12
    fault_from_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_instr) |=> !fault);

    // R12
    vec_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |-> (fault || trap));

    // R4
    fault_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (hit_vec != '0));

endmodule

bind bkpt_match_unit bkpt_chk #(.NUM_BP(NUM_BP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_instr (acc_instr),
    .acc_class (acc_class),
    .commit    (commit),
    .hit_vec   (hit_vec),
    .fault     (fault),
    .trap      (trap)
);

// File: tb/sim_bkpt_match_unit.sv
`timescale 1ns/1ps
module sim_bkpt_match_unit;

    typedef struct packed {
        logic [63:0] addr;
        logic [3:0]  lm1;
        logic        vld;
        logic        wr;
        logic        ins;
        logic        m32;
        logic [3:0]  cls;
        logic        cmt;
        logic [3:0]  evec;
        logic        ef;
        logic        et;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    // entries: e0 0x1000/16B r ; e1 0x2000/1B r+w ; e2 0x4000/256B x ; e3 0x0/8B r+w
    localparam vec_t VEC [NV] = '{
        '{64'h1008, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd1},  // R1 inside
        '{64'h0FFE, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd1},  // R1 straddle
        '{64'h0FF8, 4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd2},  // R2 just below
        '{64'h1004, 4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd3},  // R3 no write en
        '{64'h1FFF, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'b0010, 1'b0, 1'b1, 4'd1},  // R1 last byte
        '{64'h2001, 4'd15,1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd2},  // R2 just above
        '{64'hFFFF_FFFF_FFFF_FFFE, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'b1000, 1'b0, 1'b1, 4'd1}, // R1 wrap
        '{64'hFFFF_FFFF_FFFF_FFF0, 4'd13,1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd2}, // R2 top
        '{64'h40FF, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 4'b0100, 1'b1, 1'b0, 4'd4},  // R4 fetch hit
        '{64'h3FFF, 4'd7, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd4},  // R4 first byte only
        '{64'h4000, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd3},  // R3 exec-only entry
        '{64'h1000, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd4},  // R4 no exec en
        '{64'h0FF8, 4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 4'b0001, 1'b0, 1'b1, 4'd6},  // R6 widened read
        '{64'h1FF8, 4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 1'b0, 4'b0010, 1'b0, 1'b1, 4'd6},  // R6 widened write
        '{64'h1008, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd7},  // R7 flush
        '{64'h1008, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd7},  // R7 probe
        '{64'h1008, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd7},  // R7 prefetch
        '{64'h1008, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd7},  // R7 tlb insert
        '{64'h2000, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd7},  // R7 tlb purge
        '{64'h0004, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd7},  // R7 xlate
        '{64'h1008, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd8},  // R8 park
        '{64'h0,    4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'b0001, 1'b0, 1'b1, 4'd8},  // R8 release
        '{64'h0,    4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'b0000, 1'b0, 1'b0, 4'd8},  // R8 empty commit
        '{64'h2000, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd8},  // R8 park e1
        '{64'h0004, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd9},  // R9 merge e3
        '{64'h1008, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 1'b1, 4'b1010, 1'b0, 1'b1, 4'd9},  // R9 commit+new park
        '{64'h2000, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'b0011, 1'b0, 1'b1, 4'd9},  // R9 commit+plain hit
        '{64'h0,    4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'b0000, 1'b0, 1'b0, 4'd9},  // R9 nothing left
        '{64'h4010, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b1, 4'b0100, 1'b1, 1'b0, 4'd12}, // R12 fetch+commit
        '{64'h2000, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9, 1'b0, 4'b0010, 1'b0, 1'b1, 4'd7},  // R7 class 9 ordinary
        '{64'h1008, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd10}  // R10 invalid idle
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bp_load = 1'b0;
    logic [1:0]  bp_sel = '0;
    logic [63:0] bp_base = '0, bp_mask = '0;
    logic        bp_rd_en = 1'b0, bp_wr_en = 1'b0, bp_ex_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic [63:0] acc_addr = '0;
    logic [3:0]  acc_len_m1 = '0;
    logic        acc_write = 1'b0, acc_instr = 1'b0, acc_mode32 = 1'b0;
    logic [3:0]  acc_class = '0;
    logic        commit = 1'b0;
    logic [3:0]  hit_vec;
    logic        fault, trap;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bkpt_match_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .bp_load(bp_load), .bp_sel(bp_sel), .bp_base(bp_base), .bp_mask(bp_mask),
        .bp_rd_en(bp_rd_en), .bp_wr_en(bp_wr_en), .bp_ex_en(bp_ex_en),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_len_m1(acc_len_m1),
        .acc_write(acc_write), .acc_instr(acc_instr), .acc_mode32(acc_mode32),
        .acc_class(acc_class), .commit(commit),
        .hit_vec(hit_vec), .fault(fault), .trap(trap)
    );

    task automatic load_bp(input logic [1:0] s, input logic [63:0] b, input logic [63:0] m,
                           input logic r, input logic w, input logic x);
        @(negedge clk);
        bp_load = 1'b1; bp_sel = s; bp_base = b; bp_mask = m;
        bp_rd_en = r; bp_wr_en = w; bp_ex_en = x;
        @(negedge clk);
        bp_load = 1'b0;
    endtask

    task automatic check(input logic [3:0] ev, input logic ef, input logic et, input int rq);
        n_chk++;
        if (hit_vec !== ev || fault !== ef || trap !== et) begin
            n_bad++;
            $display("FAIL R%0d: got vec=%b fault=%b trap=%b, expected vec=%b fault=%b trap=%b",
                     rq, hit_vec, fault, trap, ev, ef, et);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        acc_addr = v.addr; acc_len_m1 = v.lm1; acc_valid = v.vld; acc_write = v.wr;
        acc_instr = v.ins; acc_mode32 = v.m32; acc_class = v.cls; commit = v.cmt;
        @(posedge clk);
        #5;
        check(v.evec, v.ef, v.et, int'(v.req));
    endtask

    task automatic go_idle();
        @(negedge clk);
        acc_valid = 1'b0; commit = 1'b0;
    endtask

    initial begin
        vec_t d;
        repeat (3) @(posedge clk);
        #5;
        check(4'b0000, 1'b0, 1'b0, 11);  // R11 outputs clear in reset
        @(negedge clk);
        rst_n = 1'b1;

        load_bp(2'd0, 64'h1000, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1, 1'b0, 1'b0);
        load_bp(2'd1, 64'h2000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0);
        load_bp(2'd2, 64'h4000, 64'hFFFF_FFFF_FFFF_FF00, 1'b0, 1'b0, 1'b1);
        load_bp(2'd3, 64'h0000, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R10 a hit lasts one cycle only
        apply(VEC[0]);
        go_idle();
        @(posedge clk); #5;
        check(4'b0000, 1'b0, 1'b0, 10);

        // R5 upper base bits nonzero: blocked in 32-bit mode, matches otherwise
        load_bp(2'd2, 64'h0000_0001_0000_4000, 64'h0000_0000_FFFF_FF00, 1'b0, 1'b0, 1'b1);
        d = '{64'h4000, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd5};
        apply(d);
        d.m32 = 1'b0; d.evec = 4'b0100; d.ef = 1'b1;
        apply(d);

        // R11 reset drops parked hits and entry enables
        d = '{64'h1008, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd8};
        apply(d);
        @(negedge clk);
        acc_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        d = '{64'h0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'b0000, 1'b0, 1'b0, 4'd11};
        apply(d);
        d = '{64'h1008, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd11};
        apply(d);
        go_idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got no completion, expected end of run");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule